// File: doc/BRIEF.md
# Serial Control Register File Slave

This block is the peripheral end of a four-wire serial control port. A host selects it by pulling the active-low select line low. It then clocks in a 32-bit frame, most significant bit first. The frame is an 8-bit command byte, an 8-bit register address and a 16-bit data word. Behind the port sits a bank of sixteen 16-bit control registers, two of which come out of reset with non-zero values.

A write command stores the data word in the addressed register. A read command ignores the data-in line after the address byte and shifts the addressed register out on the data-out line. The block drives data-out only while it is selected. After every completed read or write, a ready output goes low for a fixed number of system clocks, standing in for the execution time of the command. The serial lines are asynchronous to the system clock. They are synchronised and oversampled, so the serial clock must be several times slower than the system clock.

Top module: `ctrl_port_slave`

## Requirements
- R1: After reset, register 0 reads 0x4800, register 1 reads 0x000C, and every other register, including registers 2 and 3, reads 0x0000. `busy_n` is 1 and `sdo_en` is 0.
- R2: A frame is sampled on rising `sck` edges while `cs_n` is low, most significant bit first, as command[7:0], address[7:0], data[15:0]. Command 0x02 with an address below 0x10 stores the data in that register.
- R3: Command 0x03 shifts the addressed register out on `sdo`, most significant bit first. The line changes after the falling `sck` edges that follow rising edges 16 through 31, so each bit is valid before the next rising edge. `sdi` during the data phase of a read leaves every register unchanged.
- R4: An address of 0x10 or above changes no register on write, including the register that shares its low four bits, and reads back as 0x0000.
- R5: Any command other than 0x02 or 0x03 causes the rest of the frame to be ignored: no register changes and `busy_n` stays high.
- R6: A rise of `cs_n` before the 32nd rising `sck` edge aborts the frame with no register change. The next frame decodes from its first bit.
- R7: When the rise of `cs_n` and the 32nd rising `sck` edge arrive together, the abort wins and no write takes place.
- R8: After each completed read or write, `busy_n` goes low for exactly `BUSY_CYCLES` system clocks (8 by default), then returns high.
- R9: `sdo_en` is 1 while the block is selected and 0 while `cs_n` is high. `sdo` is high impedance whenever `sdo_en` is 0.
- R10: Rising `sck` edges after the 32nd in one selection are ignored. The completed command stands as decoded from the first 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select, asynchronous |
| sck | input | 1 | Serial clock, asynchronous, slower than clk |
| sdi | input | 1 | Serial data in, sampled on rising sck |
| sdo | output | 1 | Serial data out, high impedance when not selected |
| sdo_en | output | 1 | Drive enable for sdo |
| busy_n | output | 1 | Ready flag, low while a command executes |

## Verification
The deselect path and the frame-completion path can act in the same system cycle. This happens when the rise of `cs_n` and the last rising `sck` edge pass through the synchroniser together. The bench provokes it by sending 31 bits of a write and then raising `cs_n` and `sck` at the same instant. It then reads the target register back and checks that it is unchanged and that no busy pulse appeared, which shows that the abort takes priority over the commit.

// File: rtl/ctlslv_pkg.sv
package ctlslv_pkg;
  localparam int REG_W = 16;
  localparam int OPC_W = 8;
  localparam int ADR_W = 8;

  localparam logic [OPC_W-1:0] OPC_STORE = 8'h02;
  localparam logic [OPC_W-1:0] OPC_FETCH = 8'h03;

  // Power-on contents of the register bank
  function automatic logic [REG_W-1:0] reg_reset_value(input int idx);
    case (idx)
      0:       return 16'h4800;
      1:       return 16'h000C;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/ctlslv_sync.sv
module ctlslv_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= IDLE;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ctlslv_regbank.sv
module ctlslv_regbank
  import ctlslv_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W = REG_W,
  parameter int AW = ADR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int IDX_W = $clog2(NUM_REGS);

  logic [DATA_W-1:0] bank [NUM_REGS];
  logic              wr_hit;
  logic              rd_hit;

  assign wr_hit = wr_addr < AW'(NUM_REGS);
  assign rd_hit = rd_addr < AW'(NUM_REGS);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) bank[i] <= DATA_W'(reg_reset_value(i));
    end else if (wr_en && wr_hit) begin
      bank[wr_addr[IDX_W-1:0]] <= wr_data;
    end
  end

  assign rd_data = rd_hit ? bank[rd_addr[IDX_W-1:0]] : '0;
endmodule

// File: rtl/ctlslv_frame.sv
module ctlslv_frame
  import ctlslv_pkg::*;
#(
  parameter int DATA_W = REG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_s,
  input  logic              sck_s,
  input  logic              sdi_s,
  output logic [ADR_W-1:0]  rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_en,
  output logic [ADR_W-1:0]  wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              cmd_done,
  output logic              sdo_q,
  output logic              sdo_en
);
  localparam int HDR   = OPC_W + ADR_W;
  localparam int FRAME = HDR + DATA_W;
  localparam int CNT_W = $clog2(FRAME + 1);
  localparam int SH_W  = (HDR > DATA_W) ? HDR : DATA_W;

  logic              sck_d;
  logic              sck_rise, sck_fall;
  logic [CNT_W-1:0]  cnt;
  logic [SH_W-2:0]   shin;
  logic [SH_W-1:0]   shin_nx;
  logic [OPC_W-1:0]  op_q;
  logic [ADR_W-1:0]  adr_q;
  logic              rd_act;
  logic [DATA_W-1:0] shout;
  logic [OPC_W-1:0]  op_nx;

  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;
  assign shin_nx  = {shin, sdi_s};
  assign op_nx    = shin_nx[HDR-1:ADR_W];
  assign rd_addr  = shin_nx[ADR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d    <= 1'b0;
      cnt      <= '0;
      shin     <= '0;
      op_q     <= '0;
      adr_q    <= '0;
      rd_act   <= 1'b0;
      shout    <= '0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      cmd_done <= 1'b0;
      sdo_q    <= 1'b0;
      sdo_en   <= 1'b0;
    end else begin
      sck_d    <= sck_s;
      wr_en    <= 1'b0;
      cmd_done <= 1'b0;
      sdo_en   <= ~cs_s;
      if (cs_s) begin
        // deselect has priority over any edge seen in the same cycle
        cnt    <= '0;
        rd_act <= 1'b0;
        sdo_q  <= 1'b0;
      end else if (sck_rise && cnt < CNT_W'(FRAME)) begin
        cnt  <= cnt + 1'b1;
        shin <= shin_nx[SH_W-2:0];
        if (cnt == CNT_W'(HDR - 1)) begin
          op_q  <= op_nx;
          adr_q <= shin_nx[ADR_W-1:0];
          if (op_nx == OPC_FETCH) begin
            rd_act <= 1'b1;
            shout  <= rd_data;
          end
        end
        if (cnt == CNT_W'(FRAME - 1)) begin
          if (op_q == OPC_STORE) begin
            wr_en   <= 1'b1;
            wr_addr <= adr_q;
            wr_data <= shin_nx[DATA_W-1:0];
          end
          cmd_done <= (op_q == OPC_STORE) || (op_q == OPC_FETCH);
        end
      end else if (sck_fall && rd_act && cnt >= CNT_W'(HDR) && cnt < CNT_W'(FRAME)) begin
        sdo_q <= shout[DATA_W-1];
        shout <= {shout[DATA_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/ctlslv_busy.sv
module ctlslv_busy #(
  parameter int BUSY_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy_n
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [CNT_W-1:0] cnt, cnt_nx;

  always_comb begin
    if (start)            cnt_nx = CNT_W'(BUSY_CYCLES);
    else if (cnt != '0)   cnt_nx = cnt - 1'b1;
    else                  cnt_nx = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      busy_n <= 1'b1;
    end else begin
      cnt    <= cnt_nx;
      busy_n <= (cnt_nx == '0);
    end
  end
endmodule

// File: rtl/ctrl_port_slave.sv
module ctrl_port_slave
  import ctlslv_pkg::*;
#(
  parameter int NUM_REGS    = 16,
  parameter int BUSY_CYCLES = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic sdi,
  output logic sdo,
  output logic sdo_en,
  output logic busy_n
);
  logic [2:0]       raw_w, syn_w;
  logic [ADR_W-1:0] rd_addr_w, wr_addr_w;
  logic [REG_W-1:0] rd_data_w, wr_data_w;
  logic             wr_en_w, done_w, sdo_w;

  assign raw_w = {cs_n, sck, sdi};

  ctlslv_sync #(.W(3), .STAGES(SYNC_STAGES), .IDLE(3'b100)) sync_i (
    .clk(clk), .rst(rst), .d(raw_w), .q(syn_w)
  );

  ctlslv_frame #(.DATA_W(REG_W)) frame_i (
    .clk(clk), .rst(rst),
    .cs_s(syn_w[2]), .sck_s(syn_w[1]), .sdi_s(syn_w[0]),
    .rd_addr(rd_addr_w), .rd_data(rd_data_w),
    .wr_en(wr_en_w), .wr_addr(wr_addr_w), .wr_data(wr_data_w),
    .cmd_done(done_w), .sdo_q(sdo_w), .sdo_en(sdo_en)
  );

  ctlslv_regbank #(.NUM_REGS(NUM_REGS), .DATA_W(REG_W), .AW(ADR_W)) bank_i (
    .clk(clk), .rst(rst),
    .wr_en(wr_en_w), .wr_addr(wr_addr_w), .wr_data(wr_data_w),
    .rd_addr(rd_addr_w), .rd_data(rd_data_w)
  );

  ctlslv_busy #(.BUSY_CYCLES(BUSY_CYCLES)) busy_i (
    .clk(clk), .rst(rst), .start(done_w), .busy_n(busy_n)
  );

  assign sdo = sdo_en ? sdo_w : 1'bz;
endmodule

// File: rtl/ctlslv_checker.sv
module ctlslv_checker #(
  parameter int BUSY_CYCLES = 8
) (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic busy_n,
  input logic sdo_en,
  input logic wr_en,
  input logic cmd_done
);
  localparam int RUN_W = $clog2(BUSY_CYCLES + 2) + 1;

  logic [RUN_W-1:0] run_len;

  always_ff @(posedge clk) begin
    if (rst)          run_len <= '0;
    else if (!busy_n) run_len <= run_len + 1'b1;
    else              run_len <= '0;
  end

  // R8: a low window on busy_n lasts exactly BUSY_CYCLES clocks
  a_r8_busy_len: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_n) |-> (run_len == RUN_W'(BUSY_CYCLES)));

  // R8: a completed command pulls busy_n low on the next clock
  a_r8_busy_start: assert property (@(posedge clk) disable iff (rst)
    cmd_done |=> !busy_n);

  // R5: busy_n only falls after a completed read or write
  a_r5_busy_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_n) |-> $past(cmd_done));

  // R9: a long idle select line leaves the output undriven
  a_r9_idle_undriven: assert property (@(posedge clk) disable iff (rst)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !sdo_en);

  // R6: no register write while deselected
  a_r6_no_write_idle: assert property (@(posedge clk) disable iff (rst)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !wr_en);
endmodule

bind ctrl_port_slave ctlslv_checker #(.BUSY_CYCLES(BUSY_CYCLES)) chk_i (
  .clk(clk), .rst(rst), .cs_n(cs_n), .busy_n(busy_n), .sdo_en(sdo_en),
  .wr_en(wr_en_w), .cmd_done(done_w)
);

// File: tb/ctrl_port_slave_tb.sv
`timescale 1ns/1ps
module ctrl_port_slave_tb_top;
  localparam int HALF = 8;
  localparam int BUSY = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1;
  logic sck = 1'b0;
  logic sdi = 1'b0;
  wire  sdo;
  logic sdo_en;
  logic busy_n;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  int low_cnt = 0;
  int last_len = 0;
  int runs = 0;

  always #2.5 clk = ~clk;

  ctrl_port_slave #(.BUSY_CYCLES(BUSY)) dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .sdo(sdo), .sdo_en(sdo_en), .busy_n(busy_n)
  );

  always @(negedge clk) begin
    if (rst) low_cnt = 0;
    else if (!busy_n) low_cnt = low_cnt + 1;
    else if (low_cnt != 0) begin
      last_len = low_cnt;
      runs = runs + 1;
      low_cnt = 0;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] op, input logic [7:0] adr, input logic [15:0] dat,
                      input int nbits, input bit same_edge, output logic [15:0] rx);
    logic [31:0] w;
    w = {op, adr, dat};
    rx = '0;
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 32) ? w[31-i] : 1'b1;
      wait_clk(HALF);
      if (i >= 16 && i < 32) rx[31-i] = sdo;
      sck = 1'b1;
      if (same_edge && i == nbits - 1) cs_n = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(4 * HALF);
  endtask

  task automatic write_reg(input logic [7:0] adr, input logic [15:0] dat);
    logic [15:0] d;
    xfer(8'h02, adr, dat, 32, 1'b0, d);
  endtask

  task automatic read_reg(input logic [7:0] adr, output logic [15:0] v);
    xfer(8'h03, adr, 16'h0000, 32, 1'b0, v);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    check(busy_n === 1'b1, "R1 busy_n after reset", 32'(busy_n), 1);
    check(sdo_en === 1'b0, "R1 sdo_en after reset", 32'(sdo_en), 0);
    read_reg(8'h00, v); check(v == 16'h4800, "R1 reg0 reset", v, 16'h4800);
    read_reg(8'h01, v); check(v == 16'h000C, "R1 reg1 reset", v, 16'h000C);
    read_reg(8'h02, v); check(v == 16'h0000, "R1 reg2 reset", v, 0);
    read_reg(8'h03, v); check(v == 16'h0000, "R1 reg3 reset", v, 0);
    read_reg(8'h05, v); check(v == 16'h0000, "R1 reg5 reset", v, 0);
  endtask

  task automatic t_write();
    logic [15:0] v;
    int r0;
    r0 = runs;
    write_reg(8'h03, 16'hA5C3);
    check(runs == r0 + 1, "R8 busy window after write", runs, r0 + 1);
    check(last_len == BUSY, "R8 busy length after write", last_len, BUSY);
    read_reg(8'h03, v); check(v == 16'hA5C3, "R2 write reg3", v, 16'hA5C3);
    check(runs == r0 + 2, "R8 busy window after read", runs, r0 + 2);
    check(last_len == BUSY, "R8 busy length after read", last_len, BUSY);
    write_reg(8'h0F, 16'h8001);
    read_reg(8'h0F, v); check(v == 16'h8001, "R2 write reg15", v, 16'h8001);
    write_reg(8'h00, 16'h1234);
    read_reg(8'h00, v); check(v == 16'h1234, "R2 write reg0", v, 16'h1234);
  endtask

  task automatic t_read_ignores_sdi();
    logic [15:0] v;
    xfer(8'h03, 8'h0F, 16'hFFFF, 32, 1'b0, v);
    check(v == 16'h8001, "R3 read with busy sdi", v, 16'h8001);
    read_reg(8'h0F, v); check(v == 16'h8001, "R3 register unchanged by read", v, 16'h8001);
  endtask

  task automatic t_bad_addr();
    logic [15:0] v;
    write_reg(8'h05, 16'h0F0F);
    write_reg(8'h15, 16'h7777);
    read_reg(8'h05, v); check(v == 16'h0F0F, "R4 alias reg5 untouched", v, 16'h0F0F);
    read_reg(8'h15, v); check(v == 16'h0000, "R4 high address reads zero", v, 0);
  endtask

  task automatic t_bad_op();
    logic [15:0] v;
    int r0;
    r0 = runs;
    xfer(8'h07, 8'h03, 16'h5555, 32, 1'b0, v);
    check(runs == r0, "R5 no busy on unknown command", runs, r0);
    read_reg(8'h03, v); check(v == 16'hA5C3, "R5 reg3 untouched", v, 16'hA5C3);
  endtask

  task automatic t_abort();
    logic [15:0] v;
    int r0;
    r0 = runs;
    xfer(8'h02, 8'h04, 16'hBEEF, 20, 1'b0, v);
    check(runs == r0, "R6 no busy on aborted frame", runs, r0);
    read_reg(8'h04, v); check(v == 16'h0000, "R6 aborted write", v, 0);
    write_reg(8'h04, 16'h4321);
    read_reg(8'h04, v); check(v == 16'h4321, "R6 frame after abort", v, 16'h4321);
  endtask

  task automatic t_same_edge();
    logic [15:0] v;
    int r0;
    r0 = runs;
    xfer(8'h02, 8'h06, 16'hCAFE, 32, 1'b1, v);
    check(runs == r0, "R7 no busy when deselect meets last edge", runs, r0);
    read_reg(8'h06, v); check(v == 16'h0000, "R7 abort wins", v, 0);
  endtask

  task automatic t_extra_bits();
    logic [15:0] v;
    xfer(8'h02, 8'h07, 16'h1357, 40, 1'b0, v);
    read_reg(8'h07, v); check(v == 16'h1357, "R10 trailing bits ignored", v, 16'h1357);
  endtask

  task automatic t_output_enable();
    cs_n = 1'b0;
    wait_clk(6);
    check(sdo_en === 1'b1, "R9 enable while selected", 32'(sdo_en), 1);
    cs_n = 1'b1;
    wait_clk(6);
    check(sdo_en === 1'b0, "R9 disable when deselected", 32'(sdo_en), 0);
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    wait_clk(5);
    rst = 1'b0;
    wait_clk(5);
    t_reset();
    t_write();
    t_read_ignores_sdi();
    t_bad_addr();
    t_bad_op();
    t_abort();
    t_same_edge();
    t_extra_bits();
    t_output_enable();
    finish_run();
  end
endmodule